// File: doc/BRIEF.md
# Hidden Instruction Table Indirection Unit

This unit sits in the decode stage of a processor pipeline and lets a program carry some of its instructions out of sight. A fetched word whose primary opcode equals a reserved escape value is not decoded as itself. Instead, a five-bit slot number taken from that word selects one of 32 full 32-bit instructions held in a private table, and that table entry goes to the decoder. Every other fetched word goes to the decoder unchanged. The program image alone therefore does not show the code that actually runs.

The table is filled through a write-only load port. A write lands only while the load-enable input is high, and no path reads the table back. A slot that has never been written since reset returns an all-zero word, which is a no-operation, and raises a one-cycle miss flag. Both the direct path and the table path pass through the same output register, so the unit adds exactly one cycle whichever path a word takes.

Top module: `insn_indirect_unit`

## Requirements
- R1: While rst_n is low, out_valid and out_miss are 0 and out_insn is all zeros.
- R2: A word accepted with in_valid high whose bits 31:26 differ from 6'h3E appears unchanged on out_insn, with out_valid high and out_miss low, on the cycle after the clock edge that accepted it.
- R3: A word accepted with in_valid high whose bits 31:26 equal 6'h3E is replaced, on the cycle after acceptance, by the table slot named by its bits 25:21, with the same one-cycle latency as R2.
- R4: An escape word that names a slot not written since reset yields out_insn all zeros with out_miss high and out_valid high for that one cycle.
- R5: A table write (ld_wr high at a clock edge) stores ld_data in slot ld_idx only if ld_en is also high at that edge; otherwise the table is unchanged.
- R6: When a write and an escape lookup of the same slot share a clock edge, the lookup returns the slot's content from before that edge (or a miss if it was unwritten).
- R7: The cycle after an edge at which in_valid is low, out_valid and out_miss are 0 and out_insn is all zeros, whatever in_insn held.
- R8: Writing a slot that already holds a word replaces it; later lookups return the newest word.
- R9: In an escape word, bits 20:0 have no effect on the output.
- R10: Reset forgets every slot: after reset, a lookup of a slot written before it is a miss (R4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Fetched word is present |
| in_insn | input | 32 | Fetched instruction word |
| ld_en | input | 1 | Table load permission |
| ld_wr | input | 1 | Table write strobe |
| ld_idx | input | 5 | Table slot to write |
| ld_data | input | 32 | Word to store in the slot |
| out_valid | output | 1 | Resolved word is present |
| out_insn | output | 32 | Resolved instruction for the decoder |
| out_miss | output | 1 | Lookup hit a never-written slot |

## Verification
The bench goes after the edges where the two paths meet: a write and a lookup of one slot on the same edge (a design that forwards the new word breaks R6), escape words whose low 21 bits are random (a decoder that takes the slot number from the wrong field or compares more than the opcode breaks R9), and write strobes with the load permission low (a design that ignores the permission fills the slot, so the following lookup hits instead of missing). It also issues a reset after the table is full and then reads old slots; a design that keeps its written marks across reset returns stale words instead of the zero word with the miss flag. Words whose opcode differs from the escape value by one bit test that ordinary code is never mistaken for an escape.

// File: rtl/insn_ind_pkg.sv
package insn_ind_pkg;

   // width of the primary opcode field, always the top bits of a word
   localparam int unsigned OPC_W = 6;

   // how a presented word was resolved
   typedef enum logic [1:0] {
      RK_IDLE = 2'd0,
      RK_PASS = 2'd1,
      RK_HIT  = 2'd2,
      RK_MISS = 2'd3
   } res_kind_e;

   function automatic logic kind_valid(input res_kind_e k);
      return k != RK_IDLE;
   endfunction

endpackage

// File: rtl/iiu_classify.sv
module iiu_classify
   import insn_ind_pkg::*;
#(
   parameter int unsigned          INSN_W  = 32,
   parameter int unsigned          IDX_W   = 5,
   parameter int unsigned          IDX_LSB = 21,
   parameter logic [OPC_W-1:0]     ESC_OP  = 6'h3E
) (
   input  logic [INSN_W-1:0] in_insn,
   output logic              is_esc,
   output logic [IDX_W-1:0]  slot
);

   localparam int unsigned OPC_LSB = INSN_W - OPC_W;

   if (IDX_LSB + IDX_W > OPC_LSB) begin : g_bad_field
      $error("slot field overlaps the opcode field");
   end

   logic [OPC_W-1:0] opc;

   assign opc    = in_insn[OPC_LSB +: OPC_W];
   assign is_esc = (opc == ESC_OP);
   assign slot   = in_insn[IDX_LSB +: IDX_W];

endmodule

// File: rtl/iiu_store.sv
module iiu_store #(
   parameter int unsigned INSN_W = 32,
   parameter int unsigned IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [INSN_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [INSN_W-1:0] rd_data,
   output logic              rd_hit
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [INSN_W-1:0] cells [DEPTH];
   logic [DEPTH-1:0]  filled;
   logic [DEPTH-1:0]  wr_sel;

   // one-hot slot decode, repeated per slot
   for (genvar e = 0; e < DEPTH; e++) begin : g_dec
      assign wr_sel[e] = wr_en && (wr_idx == IDX_W'(e));
   end

   // contents carry no reset; only the filled marks do
   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filled <= '0;
      else        filled <= filled | wr_sel;
   end

   assign rd_data = cells[rd_idx];
   assign rd_hit  = filled[rd_idx];

endmodule

// File: rtl/iiu_resolve.sv
module iiu_resolve
   import insn_ind_pkg::*;
#(
   parameter int unsigned INSN_W  = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_insn,
   input  logic              is_esc,
   input  logic              tbl_hit,
   input  logic [INSN_W-1:0] tbl_data,
   output logic              out_valid,
   output logic [INSN_W-1:0] out_insn,
   output logic              out_miss
);

   res_kind_e         kind;
   logic [INSN_W-1:0] nxt_insn;

   always_comb begin
      if (!in_valid)    kind = RK_IDLE;
      else if (!is_esc) kind = RK_PASS;
      else if (tbl_hit) kind = RK_HIT;
      else              kind = RK_MISS;
   end

   always_comb begin
      unique case (kind)
         RK_PASS: nxt_insn = in_insn;
         RK_HIT:  nxt_insn = tbl_data;
         default: nxt_insn = '0;
      endcase
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_insn  <= '0;
            out_miss  <= 1'b0;
         end else begin
            out_valid <= kind_valid(kind);
            out_insn  <= nxt_insn;
            out_miss  <= (kind == RK_MISS);
         end
      end
   end else begin : g_comb
      assign out_valid = rst_n && kind_valid(kind);
      assign out_insn  = rst_n ? nxt_insn : '0;
      assign out_miss  = rst_n && (kind == RK_MISS);
   end

endmodule

// File: rtl/insn_indirect_unit.sv
module insn_indirect_unit
   import insn_ind_pkg::*;
#(
   parameter int unsigned      INSN_W  = 32,
   parameter int unsigned      IDX_W   = 5,
   parameter int unsigned      IDX_LSB = 21,
   parameter logic [OPC_W-1:0] ESC_OP  = 6'h3E,
   parameter bit               OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_insn,
   input  logic              ld_en,
   input  logic              ld_wr,
   input  logic [IDX_W-1:0]  ld_idx,
   input  logic [INSN_W-1:0] ld_data,
   output logic              out_valid,
   output logic [INSN_W-1:0] out_insn,
   output logic              out_miss
);

   if (INSN_W < 16) begin : g_bad_width
      $error("instruction width too small");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("slot number width out of range");
   end

   logic              esc;
   logic [IDX_W-1:0]  slot;
   logic [INSN_W-1:0] tbl_word;
   logic              tbl_hit;
   logic              tbl_we;

   assign tbl_we = ld_en & ld_wr;

   iiu_classify #(
      .INSN_W (INSN_W),
      .IDX_W  (IDX_W),
      .IDX_LSB(IDX_LSB),
      .ESC_OP (ESC_OP)
   ) u_cls (
      .in_insn(in_insn),
      .is_esc (esc),
      .slot   (slot)
   );

   iiu_store #(
      .INSN_W(INSN_W),
      .IDX_W (IDX_W)
   ) u_tbl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_we),
      .wr_idx (ld_idx),
      .wr_data(ld_data),
      .rd_idx (slot),
      .rd_data(tbl_word),
      .rd_hit (tbl_hit)
   );

   iiu_resolve #(
      .INSN_W (INSN_W),
      .OUT_REG(OUT_REG)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_insn  (in_insn),
      .is_esc   (esc),
      .tbl_hit  (tbl_hit),
      .tbl_data (tbl_word),
      .out_valid(out_valid),
      .out_insn (out_insn),
      .out_miss (out_miss)
   );

endmodule

// File: rtl/insn_indirect_chk.sv
module insn_indirect_chk
   import insn_ind_pkg::*;
#(
   parameter int unsigned      INSN_W  = 32,
   parameter logic [OPC_W-1:0] ESC_OP  = 6'h3E,
   parameter bit               OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [INSN_W-1:0] in_insn,
   input logic              out_valid,
   input logic [INSN_W-1:0] out_insn,
   input logic              out_miss
);

   localparam int unsigned OPC_LSB = INSN_W - OPC_W;

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && !out_miss && out_insn == '0));

   a_r4_miss_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
      out_miss |-> (out_valid && out_insn == '0));

   a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_miss && out_insn == '0));

   if (OUT_REG) begin : g_lat
      // R3: both paths share one cycle of latency
      a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (out_valid == $past(in_valid)));

      a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(in_valid) && $past(in_insn[OPC_LSB +: OPC_W]) != ESC_OP)
         |-> (out_insn == $past(in_insn) && !out_miss));
   end

endmodule

bind insn_indirect_unit insn_indirect_chk #(
   .INSN_W (INSN_W),
   .ESC_OP (ESC_OP),
   .OUT_REG(OUT_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_insn  (in_insn),
   .out_valid(out_valid),
   .out_insn (out_insn),
   .out_miss (out_miss)
);

// File: tb/sim_insn_indirect_unit.sv
`timescale 1ns/1ps
module sim_insn_indirect_unit;

   localparam logic [5:0] ESC = 6'h3E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic        ld_en = 1'b0;
   logic        ld_wr = 1'b0;
   logic [4:0]  ld_idx = '0;
   logic [31:0] ld_data = '0;
   logic        out_valid;
   logic [31:0] out_insn;
   logic        out_miss;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   string test_tag = "R1";

   // reference model state
   logic [31:0] m_word [32];
   bit          m_set  [32];
   logic        e_valid = 1'b0;
   logic [31:0] e_insn = '0;
   logic        e_miss = 1'b0;
   string       e_tag = "R1";

   always #2.5 clk = ~clk;

   insn_indirect_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .ld_en(ld_en), .ld_wr(ld_wr), .ld_idx(ld_idx), .ld_data(ld_data),
      .out_valid(out_valid), .out_insn(out_insn), .out_miss(out_miss)
   );

   initial begin
      for (int i = 0; i < 32; i++) begin m_word[i] = '0; m_set[i] = 1'b0; end
   end

   // behavioural model: lookup sees table before this edge's write
   always @(posedge clk) begin
      if (!rst_n) begin
         e_valid = 1'b0; e_insn = '0; e_miss = 1'b0; e_tag = "R1";
         for (int i = 0; i < 32; i++) m_set[i] = 1'b0;
      end else begin
         if (!in_valid) begin
            e_valid = 1'b0; e_insn = '0; e_miss = 1'b0; e_tag = "R7";
         end else if (in_insn[31:26] != ESC) begin
            e_valid = 1'b1; e_insn = in_insn; e_miss = 1'b0; e_tag = "R2";
         end else if (m_set[in_insn[25:21]]) begin
            e_valid = 1'b1; e_insn = m_word[in_insn[25:21]]; e_miss = 1'b0; e_tag = "R3";
         end else begin
            e_valid = 1'b1; e_insn = '0; e_miss = 1'b1; e_tag = "R4";
         end
         if (ld_en && ld_wr) begin
            m_word[ld_idx] = ld_data;
            m_set[ld_idx]  = 1'b1;
         end
      end
   end

   task automatic compare();
      n_run++;
      if (out_valid !== e_valid || out_insn !== e_insn || out_miss !== e_miss) begin
         n_fail++;
         $display("FAIL %s/%s: got v=%0b insn=%08h miss=%0b, expected v=%0b insn=%08h miss=%0b",
                  test_tag, e_tag, out_valid, out_insn, out_miss, e_valid, e_insn, e_miss);
      end
   endtask

   // compare at the falling edge, then drive the next inputs
   task automatic step(input logic v, input logic [31:0] w,
                       input logic en, input logic wr, input logic [4:0] idx,
                       input logic [31:0] d);
      @(negedge clk);
      compare();
      in_valid = v; in_insn = w; ld_en = en; ld_wr = wr; ld_idx = idx; ld_data = d;
   endtask

   task automatic idle();
      step(1'b0, 32'h0, 1'b0, 1'b0, 5'd0, 32'h0);
   endtask

   function automatic logic [31:0] esc_word(input logic [4:0] s, input logic [20:0] junk);
      return {ESC, s, junk};
   endfunction

   initial begin : watchdog
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      // R1: outputs quiet in reset, even with input activity
      test_tag = "R1";
      step(1'b1, 32'h1234_5678, 1'b1, 1'b1, 5'd3, 32'hAAAA_0001);
      step(1'b1, 32'h1234_5678, 1'b0, 1'b0, 5'd0, 32'h0);
      idle();
      @(negedge clk); rst_n = 1'b1;

      // R2: ordinary words, including opcodes one bit away from escape
      test_tag = "R2";
      step(1'b1, 32'h0000_0020, 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, 32'h3E00_0000, 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, {6'h3F, 26'h155_5555}, 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, {6'h3C, 26'h2AA_AAAA}, 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, {6'h1E, 26'h3FF_FFFF}, 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R4: never-written slots miss
      test_tag = "R4";
      step(1'b1, esc_word(5'd0, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, esc_word(5'd31, 21'h1F_FFFF), 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R5: writes without permission are dropped
      test_tag = "R5";
      step(1'b0, 32'h0, 1'b0, 1'b1, 5'd7, 32'hDEAD_BEEF);
      step(1'b1, esc_word(5'd7, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R3: fill the whole table, then read it back through escapes
      test_tag = "R3";
      for (int s = 0; s < 32; s++)
         step(1'b0, 32'h0, 1'b1, 1'b1, 5'(s), 32'h0100_0000 * s + 32'h0005_0A0F ^ (s << 11));
      for (int s = 31; s >= 0; s--)
         step(1'b1, esc_word(5'(s), 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      // R3: escapes and plain words back to back
      step(1'b1, esc_word(5'd9, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, 32'h0123_4567, 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, esc_word(5'd10, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R9: low 21 bits of an escape word are ignored
      test_tag = "R9";
      for (int k = 0; k < 12; k++)
         step(1'b1, esc_word(5'(k * 5), 21'($urandom)), 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R8: rewriting replaces the content
      test_tag = "R8";
      step(1'b0, 32'h0, 1'b1, 1'b1, 5'd12, 32'hCAFE_F00D);
      step(1'b1, esc_word(5'd12, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b0, 32'h0, 1'b1, 1'b1, 5'd12, 32'h0BAD_1DEA);
      step(1'b1, esc_word(5'd12, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R6: write and lookup of one slot on the same edge return the old word
      test_tag = "R6";
      step(1'b1, esc_word(5'd12, 21'h0), 1'b1, 1'b1, 5'd12, 32'h7777_8888);
      step(1'b1, esc_word(5'd12, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R7: in_valid low produces nothing whatever in_insn holds
      test_tag = "R7";
      step(1'b0, esc_word(5'd12, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R10: reset clears the written marks
      test_tag = "R10";
      @(negedge clk); compare(); rst_n = 1'b0;
      idle();
      @(negedge clk); compare(); rst_n = 1'b1;
      step(1'b1, esc_word(5'd12, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      step(1'b1, esc_word(5'd0, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      // R6 after reset: same-edge write to an unwritten slot still misses
      step(1'b1, esc_word(5'd4, 21'h0), 1'b1, 1'b1, 5'd4, 32'h4444_4444);
      step(1'b1, esc_word(5'd4, 21'h0), 1'b0, 1'b0, 5'd0, 32'h0);
      idle();

      // R2 R3 R4 R5 R7: random mixed traffic
      test_tag = "MIX";
      for (int k = 0; k < 600; k++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0],
              r[1] ? esc_word(5'($urandom), 21'($urandom)) : $urandom,
              r[2], r[3], 5'($urandom), $urandom);
      end
      idle();
      idle();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule